// File: doc/BRIEF.md
# Watchdog Timer with Posted Register Writes

This block is a supervision timer for a system that must be restarted when its software stops responding. An up-counter advances on a slow timebase tick, optionally divided by a power-of-two prescaler. When the counter passes its all-ones value while the timer is armed, the block drives a one-cycle reset pulse. Software prevents that pulse by writing a fresh value to a trigger register, which reloads the counter from a programmable load register. The trigger value must differ from the last one written.

Arming and disarming go through an ordered pair of key words written to a dedicated start/stop register. A single stray write therefore cannot switch supervision on or off. Writes to the writable registers are posted. Each one is held in a shadow slot for a fixed number of slow ticks before it takes effect. A status register shows which slots are still busy. A second write to a busy register is dropped.

The register port is a plain single-cycle read/write strobe pair with registered read data. It exerts no back-pressure. Software is expected to poll the pending status before writing again.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the counter is 0, the timer is disarmed, every pending bit is clear, and both the control and load registers read 0. The reset output is low.
- R2: Writes to the four writable registers are posted, and each sets its own bit in the pending register at word address 6. The registers and their bits are:
  - control (address 1): bit 0
  - load (address 3): bit 2
  - trigger (address 4): bit 3
  - start/stop (address 5): bit 4

  The written value takes effect, and the bit clears, on the PEND_TICKS-th tick after the write.
- R3: A write to a register whose pending bit is set is ignored.
- R4: The timer is armed by two committed start/stop writes, 0x0000BBBB followed by 0x00004444. A read of address 5 returns the armed flag in bit 0.
- R5: The timer is disarmed by two committed start/stop writes, 0x0000AAAA followed by 0x00005555.
- R6: Only the most recent committed start/stop write counts toward a key pair. Any value other than a first key returns the sequence to idle. A first key always starts a new pair, even if it repeats the previous write.
- R7: A committed trigger write reloads the counter from the load register only when its 32-bit value differs from the previous trigger value. The previous trigger value is 0 after reset.
- R8: With control bit 5 clear, the counter (address 2) advances by one per tick. With bit 5 set, it advances once every 2^P ticks, where P is control bits 4:2.
- R9: A counter step from all-ones reloads the counter from the load register. If the timer is armed, the reset output is high for exactly the following cycle; if it is disarmed, the reset output stays low.
- R10: Address 0 reads the revision in bits 7:0. Unmapped address 7 reads 0. Writes to the read-only addresses 0, 2, 6 and 7 change nothing.
- R11: The control register reads back only bits 5:2; every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle enable marking each slow timebase tick |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| wdt_rst_o | output | 1 | One-cycle reset request |

## Verification
The assertions assume that `tick_i`, the strobes and the address are synchronous to `clk` and are sampled only at rising edges. They also assume that the reset is synchronous, so no register moves during it. The stimulus changes every input on the falling edge and holds the tick high, which makes every counter step and every commit land on a predictable edge. Writes to the same register are spaced past the pending window, except where the drop of a write to a busy register is under test.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_REV   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd2;
  localparam logic [ADDR_W-1:0] A_LOAD  = 3'd3;
  localparam logic [ADDR_W-1:0] A_TRIG  = 3'd4;
  localparam logic [ADDR_W-1:0] A_ARM   = 3'd5;
  localparam logic [ADDR_W-1:0] A_PEND  = 3'd6;

  localparam logic [DATA_W-1:0] KEY_ARM_A = 32'h0000_BBBB;
  localparam logic [DATA_W-1:0] KEY_ARM_B = 32'h0000_4444;
  localparam logic [DATA_W-1:0] KEY_DIS_A = 32'h0000_AAAA;
  localparam logic [DATA_W-1:0] KEY_DIS_B = 32'h0000_5555;

  localparam int NSLOT   = 4;
  localparam int SL_CTRL = 0;
  localparam int SL_LOAD = 1;
  localparam int SL_TRIG = 2;
  localparam int SL_ARM  = 3;

  localparam int CTRL_LSB = 2;

  typedef enum logic [1:0] {KS_IDLE, KS_ARM_HALF, KS_DIS_HALF} key_state_e;

  function automatic logic [ADDR_W-1:0] slot_addr(input int s);
    case (s)
      SL_CTRL: return A_CTRL;
      SL_LOAD: return A_LOAD;
      SL_TRIG: return A_TRIG;
      default: return A_ARM;
    endcase
  endfunction

  function automatic int pend_bit(input int s);
    case (s)
      SL_CTRL: return 0;
      SL_LOAD: return 2;
      SL_TRIG: return 3;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/wdog_posted.sv
module wdog_posted #(
  parameter int DW         = 32,
  parameter int PEND_TICKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          commit_o,
  output logic [DW-1:0] data_o
);
  localparam int CW = (PEND_TICKS > 1) ? $clog2(PEND_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PEND_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      data_q <= '0;
    end else if (!busy_q && wr_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      data_q <= wdata_i;
    end else if (busy_q && tick_i) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + CW'(1);
    end
  end

  assign busy_o   = busy_q;
  assign commit_o = busy_q && tick_i && (cnt_q == LAST);
  assign data_o   = data_q;

  AST_PEND_SET_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(wr_i)); // R2
  AST_PEND_CLEAR_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(tick_i)); // R2
  AST_BUSY_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(data_o)); // R3
endmodule

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [DATA_W-1:0] val_i,
  output logic              armed_o
);
  key_state_e st_q;
  logic       armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= KS_IDLE;
      armed_q <= 1'b0;
    end else if (commit_i) begin
      if (st_q == KS_ARM_HALF && val_i == KEY_ARM_B) begin
        armed_q <= 1'b1;
        st_q    <= KS_IDLE;
      end else if (st_q == KS_DIS_HALF && val_i == KEY_DIS_B) begin
        armed_q <= 1'b0;
        st_q    <= KS_IDLE;
      end else if (val_i == KEY_ARM_A) begin
        st_q <= KS_ARM_HALF;
      end else if (val_i == KEY_DIS_A) begin
        st_q <= KS_DIS_HALF;
      end else begin
        st_q <= KS_IDLE;
      end
    end
  end

  assign armed_o = armed_q;

  AST_ARM_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_o) |-> $past(commit_i && val_i == KEY_ARM_B)); // R4
  AST_DISARM_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed_o) |-> $past(commit_i && val_i == KEY_DIS_B)); // R5
  AST_ARM_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(armed_o)); // R6
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [PTV_W-1:0] ptv_i,
  input  logic             clr_i,
  output logic             step_o
);
  localparam int DIV_W = (1 << PTV_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic             wrap;

  assign mask   = {DIV_W{1'b1}} >> (DIV_W - int'(ptv_i));
  assign wrap   = (div_q == mask);
  assign step_o = tick_i && (!en_i || wrap);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) div_q <= '0;
    else if (tick_i && en_i) div_q <= wrap ? '0 : div_q + DIV_W'(1);
  end

  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !clr_i |=> (div_q <= $past(mask)) || $changed(ptv_i)); // R8
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] count_q;

  assign ovf_o = step_i && !reload_i && (&count_q);

  always_ff @(posedge clk) begin
    if (!rst_n)               count_q <= '0;
    else if (reload_i || ovf_o) count_q <= load_i;
    else if (step_i)          count_q <= count_q + CNT_W'(1);
  end

  assign count_o = count_q;

  AST_COUNT_MOVES_LEGALLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count_o) |-> (count_o == $past(count_o) + CNT_W'(1)) ||
                          (count_o == $past(load_i))); // R8
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int         CNT_W      = 32,
  parameter int         PEND_TICKS = 2,
  parameter int         PTV_W      = 3,
  parameter logic [7:0] REV_ID     = 8'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wdt_rst_o
);
  localparam int CTRL_W = PTV_W + 1;

  function automatic int slot_w(input int s);
    case (s)
      SL_CTRL: return CTRL_W;
      SL_LOAD: return CNT_W;
      default: return DATA_W;
    endcase
  endfunction

  function automatic int slot_lsb(input int s);
    return (s == SL_CTRL) ? CTRL_LSB : 0;
  endfunction

  logic [NSLOT-1:0]  slot_wr, slot_busy, slot_commit;
  logic [DATA_W-1:0] slot_data [NSLOT];

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      localparam int SW  = slot_w(g);
      localparam int SL  = slot_lsb(g);
      logic [SW-1:0] shadow;
      assign slot_wr[g] = wr_en_i && (addr_i == slot_addr(g));
      wdog_posted #(.DW(SW), .PEND_TICKS(PEND_TICKS)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .wr_i     (slot_wr[g]),
        .wdata_i  (wdata_i[SL +: SW]),
        .busy_o   (slot_busy[g]),
        .commit_o (slot_commit[g]),
        .data_o   (shadow)
      );
      assign slot_data[g] = DATA_W'(shadow);
    end
  endgenerate

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  load_q;
  logic [DATA_W-1:0] last_trig_q;
  logic              trig_fire;

  assign trig_fire = slot_commit[SL_TRIG] && (slot_data[SL_TRIG] != last_trig_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      load_q      <= '0;
      last_trig_q <= '0;
    end else begin
      if (slot_commit[SL_CTRL]) ctrl_q      <= slot_data[SL_CTRL][CTRL_W-1:0];
      if (slot_commit[SL_LOAD]) load_q      <= slot_data[SL_LOAD][CNT_W-1:0];
      if (slot_commit[SL_TRIG]) last_trig_q <= slot_data[SL_TRIG];
    end
  end

  logic armed;
  wdog_keyseq u_keys (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_i (slot_commit[SL_ARM]),
    .val_i    (slot_data[SL_ARM]),
    .armed_o  (armed)
  );

  logic step;
  wdog_prescale #(.PTV_W(PTV_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .en_i   (ctrl_q[PTV_W]),
    .ptv_i  (ctrl_q[PTV_W-1:0]),
    .clr_i  (slot_commit[SL_CTRL]),
    .step_o (step)
  );

  logic [CNT_W-1:0] count;
  logic             ovf;
  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_i   (step),
    .reload_i (trig_fire),
    .load_i   (load_q),
    .count_o  (count),
    .ovf_o    (ovf)
  );

  logic rst_q;
  always_ff @(posedge clk) begin
    if (!rst_n) rst_q <= 1'b0;
    else        rst_q <= armed && ovf;
  end
  assign wdt_rst_o = rst_q;

  logic [DATA_W-1:0] pend_vec, rd_val, rdata_q;

  always_comb begin
    pend_vec = '0;
    for (int i = 0; i < NSLOT; i++) pend_vec[pend_bit(i)] = slot_busy[i];
  end

  always_comb begin
    case (addr_i)
      A_REV:   rd_val = DATA_W'(REV_ID);
      A_CTRL:  rd_val = DATA_W'(ctrl_q) << CTRL_LSB;
      A_COUNT: rd_val = DATA_W'(count);
      A_LOAD:  rd_val = DATA_W'(load_q);
      A_TRIG:  rd_val = last_trig_q;
      A_ARM:   rd_val = DATA_W'(armed);
      A_PEND:  rd_val = pend_vec;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_val;
  end
  assign rdata_o = rdata_q;

  AST_RST_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> $past(armed)); // R9
  AST_RELOAD_NEEDS_NEW_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    slot_commit[SL_TRIG] && (slot_data[SL_TRIG] == last_trig_q) && !ovf && step
      |=> count == $past(count) + CNT_W'(1)); // R7
endmodule

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;
  localparam int         CNT_W = 16;
  localparam int         PT    = 2;
  localparam logic [7:0] REV   = 8'h5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wdt_rst;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_timer #(.CNT_W(CNT_W), .PEND_TICKS(PT), .PTV_W(3), .REV_ID(REV)) u_wdog_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .wdt_rst_o(wdt_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // All tasks are entered and left at a falling edge.
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic settle();
    repeat (PT + 2) @(negedge clk);
  endtask

  task automatic count_pulses(input int n, output int pulses, output int doubles);
    bit prev = 1'b0;
    pulses = 0; doubles = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wdt_rst) pulses++;
      if (wdt_rst && prev) doubles++;
      prev = wdt_rst;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a, b;
    int p, dbl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd2, v); check("R1 count", v, 0);
    check("R1 rst_o", {31'b0, wdt_rst}, 0);
    rd(3'd6, v); check("R1 pend", v, 0);
    rd(3'd5, v); check("R1 armed", v, 0);
    rd(3'd1, v); check("R1 ctrl", v, 0);
    rd(3'd3, v); check("R1 load", v, 0);

    // R10 read-only and unmapped addresses
    rd(3'd0, v); check("R10 rev", v, {24'b0, REV});
    rd(3'd7, v); check("R10 unmapped", v, 0);
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); check("R10 rev write", v, {24'b0, REV});
    rd(3'd2, a); wr(3'd2, 32'h0000_1234); rd(3'd2, b);
    check("R10 count write ignored", b - a, 2);
    wr(3'd6, 32'hFFFF_FFFF); rd(3'd6, v); check("R10 pend write", v, 0);

    // R2 pending bit per register
    begin
      logic [2:0]  adr [4] = '{3'd1, 3'd3, 3'd4, 3'd5};
      logic [31:0] bitv [4] = '{32'h01, 32'h04, 32'h08, 32'h10};
      logic [31:0] dat [4] = '{32'h0, 32'h0100, 32'h0, 32'h0};
      for (int i = 0; i < 4; i++) begin
        wr(adr[i], dat[i]);
        rd(3'd6, v); check("R2 pend set", v, bitv[i]);
        settle();
        rd(3'd6, v); check("R2 pend clear", v, 0);
      end
    end
    rd(3'd3, v); check("R2 load committed", v, 32'h0100);

    // R3 write while pending is dropped
    wr(3'd3, 32'h0200); wr(3'd3, 32'h0300); settle();
    rd(3'd3, v); check("R3 busy write dropped", v, 32'h0200);
    wr(3'd3, 32'h0100); settle();

    // R11 control readback
    wr(3'd1, 32'hFFFF_FFFF); settle();
    rd(3'd1, v); check("R11 ctrl bits", v, 32'h3C);

    // R8 prescaler sweep
    for (int k = 0; k < 8; k++) begin
      wr(3'd1, 32'h20 | (k << 2)); settle();
      rd(3'd2, a);
      repeat (3 * (1 << k) - 1) @(negedge clk);
      rd(3'd2, b);
      check($sformatf("R8 prescale k=%0d", k), (b - a) & 32'hFFFF, 3);
    end
    wr(3'd1, 32'h0); settle();
    rd(3'd2, a); repeat (9) @(negedge clk); rd(3'd2, b);
    check("R8 no prescale", (b - a) & 32'hFFFF, 10);

    // R7 trigger reload on changed value only
    wr(3'd4, 32'h0000_1234); repeat (2) @(negedge clk);
    rd(3'd2, v); check("R7 reload on new", v, 32'h0100);
    repeat (20) @(negedge clk);
    rd(3'd2, a); wr(3'd4, 32'h0000_1234); repeat (3) @(negedge clk); rd(3'd2, b);
    check("R7 same value no reload", (b - a) & 32'hFFFF, 5);
    wr(3'd4, 32'hFFFF_EDCB); repeat (2) @(negedge clk);
    rd(3'd2, v); check("R7 complement reloads", v, 32'h0100);

    // R6 broken and repeated key sequences
    wr(3'd5, 32'hBBBB); settle(); wr(3'd5, 32'h1234); settle();
    wr(3'd5, 32'h4444); settle();
    rd(3'd5, v); check("R6 broken pair", v, 0);
    wr(3'd5, 32'h4444); settle(); wr(3'd5, 32'hBBBB); settle();
    rd(3'd5, v); check("R6 half key only", v, 0);

    // R4 arm (repeated first key keeps the pair open)
    wr(3'd5, 32'hBBBB); settle(); wr(3'd5, 32'h4444); settle();
    rd(3'd5, v); check("R4 armed", v, 1);

    // R9 overflow while armed
    wr(3'd3, 32'hFFF0); settle();
    wr(3'd4, 32'h0000_0777);
    count_pulses(40, p, dbl);
    check("R9 armed pulses", p, 2);
    check("R9 single cycle", dbl, 0);
    rd(3'd2, v); check("R9 armed reload", v, 32'hFFF6);

    // R5 disarm
    wr(3'd5, 32'hAAAA); settle(); wr(3'd5, 32'h5555); settle();
    rd(3'd5, v); check("R5 disarmed", v, 0);

    // R9 overflow while disarmed
    wr(3'd4, 32'h0000_0888);
    count_pulses(40, p, dbl);
    check("R9 disarmed no pulse", p, 0);
    rd(3'd2, v); check("R9 disarmed reload", v, 32'hFFF6);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule